// File: doc/BRIEF.md
# Device Wake Handshake Controller

This block owns the host-visible general-purpose control word through which a host powers up an internal MAC domain and keeps it awake. The host writes request bits through a plain 32-bit write strobe and reads the word back combinationally. Three bits are host-writable: a full-power request (init-done), a keep-awake request (access), and a crystal-on request that drives the crystal-enable pin. The remaining defined fields are status from an internal power sequencer: clock-ready, going-to-sleep and a 3-bit power-save mode.

The sequencer has four named states. OFF is the powered-down state. WAKE counts a power-up delay. ON means the MAC clock runs. DOZE is the visible going-to-sleep window. OFF goes to WAKE when access is set, or when init-done is set and the firmware sleep request is low. WAKE goes back to OFF when that wake condition is lost, and goes to ON when its delay counter expires. ON goes to OFF when the host clears both init-done and access. ON goes to DOZE when firmware requests sleep while access is clear. DOZE goes to OFF when its sleep delay expires. Firmware asks for power-down through the fw_sleep_req input. A rising sleep request while the domain is off is a protocol error, and it shows in the mode field.

Top module: `wake_ctl_top`

## Requirements
- R1: After reset the read word is 0x0200_0000: no request bits set, clock-ready 0, going-to-sleep 0, mode 010. mac_clk_en and xtal_en are 0.
- R2: On a write, bits 2 (init-done), 3 (access) and 10 (crystal-on) take the written values. Without a write they hold. xtal_en equals bit 10.
- R3: Writes to bit 0 (clock-ready), bit 4 (going-to-sleep) and bits 26:24 (mode) are ignored. Every bit outside 0, 2, 3, 4, 10 and 26:24 reads 0.
- R4: From OFF, a write setting init-done (with sleep request low) or access makes bit 0 and mac_clk_en read 1 at the (WAKE_CYC+1)-th rising edge after the write edge. Clock-ready rises only if init-done or access was set.
- R5: While access is set and the clock is ready, fw_sleep_req is ignored and clock-ready stays 1.
- R6: With access clear and the clock ready, fw_sleep_req raises bit 4 for exactly SLEEP_CYC cycles. Clock-ready stays 1 during that window and falls at the edge where bit 4 falls.
- R7: Clock-ready never rises while bit 4 is high. With init-done set and the sleep request still high, the domain stays off. Setting access then wakes it after the R4 delay.
- R8: When the host clears both init-done and access, clock-ready falls one edge after the write, from ON or while waking.
- R9: Mode bits 26:24 read 000 in WAKE, ON and DOZE. In OFF they read 001 with crystal-on set and 010 with it clear. They read 011 on error.
- R10: A rising fw_sleep_req while OFF, with no wake condition, sets the error that R9 reports. The error stays until the sequencer next enters WAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read of the control word |
| fw_sleep_req | input | 1 | Firmware power-down request |
| mac_clk_en | output | 1 | MAC clock enable, equal to clock-ready |
| xtal_en | output | 1 | Crystal enable, equal to bit 10 |

## Verification
The bench counts the exact edge at which clock-ready rises after a request. A design with an off-by-one wake counter would miss that edge, and so would one that waits on the status rather than the request. It measures the going-to-sleep window to the cycle. A design that drops clock-ready at the start of that window, or lets the window run one cycle long, would fail there. It holds the firmware sleep request across a power-down and checks that init-done alone does not restart the domain while access does. A sequencer that loops back into WAKE would fail that check. It also writes ones into status and undefined bits, and triggers and clears the error mode, which catches writable read-only fields and an error flag that never clears.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAKE,
        ST_ON,
        ST_DOZE
    } pwr_state_e;

    typedef enum logic [2:0] {
        MODE_NONE       = 3'b000,
        MODE_MAC_DOWN   = 3'b001,
        MODE_RADIO_DOWN = 3'b010,
        MODE_ERROR      = 3'b011
    } pwr_mode_e;

    localparam int BIT_CLK_RDY = 0;
    localparam int BIT_INIT    = 2;
    localparam int BIT_ACC     = 3;
    localparam int BIT_GTS     = 4;
    localparam int BIT_XTAL    = 10;
    localparam int MODE_LO     = 24;
    localparam int MODE_HI     = 26;

endpackage

// File: rtl/wake_delay.sv
module wake_delay #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clk_rdy,
    input  logic              gts,
    input  logic [2:0]        mode,
    output logic              init_req,
    output logic              acc_req,
    output logic              xtal_req,
    output logic [DATA_W-1:0] rd_data
);
    logic unused_wr;
    assign unused_wr = ^{wr_data[DATA_W-1:BIT_XTAL+1], wr_data[BIT_XTAL-1:BIT_ACC+1],
                         wr_data[BIT_INIT-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_req <= 1'b0;
            acc_req  <= 1'b0;
            xtal_req <= 1'b0;
        end else if (wr_en) begin
            init_req <= wr_data[BIT_INIT];
            acc_req  <= wr_data[BIT_ACC];
            xtal_req <= wr_data[BIT_XTAL];
        end
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[BIT_CLK_RDY]     = clk_rdy;
        rd_data[BIT_INIT]        = init_req;
        rd_data[BIT_ACC]         = acc_req;
        rd_data[BIT_GTS]         = gts;
        rd_data[BIT_XTAL]        = xtal_req;
        rd_data[MODE_HI:MODE_LO] = mode;
    end

    // R2: a write lands the crystal request bit
    assert_xtal_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (xtal_req == $past(wr_data[BIT_XTAL])));

    // R2: request bits hold without a write
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(init_req) && $stable(acc_req) && $stable(xtal_req)));

endmodule

// File: rtl/wake_seq.sv
module wake_seq
    import wake_pkg::*;
#(
    parameter int WAKE_CYC  = 4,
    parameter int SLEEP_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_req,
    input  logic       acc_req,
    input  logic       xtal_req,
    input  logic       fw_sleep_req,
    output logic       clk_rdy,
    output logic       gts,
    output logic [2:0] mode
);
    localparam int MAX_CYC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] SLEEP_LD = CNT_W'(SLEEP_CYC - 1);

    pwr_state_e       state_q, state_d;
    logic             wake_ok;
    logic             host_req;
    logic             dly_done;
    logic             dly_load;
    logic [CNT_W-1:0] dly_val;
    logic             fw_q;
    logic             err_q;

    assign host_req = init_req | acc_req;
    assign wake_ok  = acc_req | (init_req & ~fw_sleep_req);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (wake_ok) state_d = ST_WAKE;
            ST_WAKE: begin
                if (!wake_ok)      state_d = ST_OFF;
                else if (dly_done) state_d = ST_ON;
            end
            ST_ON: begin
                if (!host_req)                     state_d = ST_OFF;
                else if (fw_sleep_req && !acc_req) state_d = ST_DOZE;
            end
            ST_DOZE: if (dly_done) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign dly_load = (state_q == ST_OFF && state_d == ST_WAKE) ||
                      (state_q == ST_ON  && state_d == ST_DOZE);
    assign dly_val  = (state_q == ST_OFF) ? WAKE_LD : SLEEP_LD;

    wake_delay #(.CNT_W(CNT_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fw_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            fw_q <= fw_sleep_req;
            if (state_q == ST_OFF && state_d == ST_WAKE)
                err_q <= 1'b0;
            else if (state_q == ST_OFF && fw_sleep_req && !fw_q)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        clk_rdy = 1'b0;
        gts     = 1'b0;
        unique case (state_q)
            ST_OFF:  begin clk_rdy = 1'b0; gts = 1'b0; end
            ST_WAKE: begin clk_rdy = 1'b0; gts = 1'b0; end
            ST_ON:   begin clk_rdy = 1'b1; gts = 1'b0; end
            ST_DOZE: begin clk_rdy = 1'b1; gts = 1'b1; end
            default: begin clk_rdy = 1'b0; gts = 1'b0; end
        endcase
        if (err_q)                 mode = MODE_ERROR;
        else if (state_q != ST_OFF) mode = MODE_NONE;
        else if (xtal_req)         mode = MODE_MAC_DOWN;
        else                       mode = MODE_RADIO_DOWN;
    end

    // R7: clock-ready never rises inside the going-to-sleep window
    assert_no_rise_in_doze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_rdy) |-> !gts);

    // R4: clock-ready rises only after a host request
    assert_rise_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_rdy) |-> $past(init_req || acc_req));

    // R5: access request shields a running clock from sleep requests
    assert_acc_blocks_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rdy && !gts && acc_req && fw_sleep_req) |=> clk_rdy);

    // R6: end of going-to-sleep removes the clock
    assert_doze_ends_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gts) |-> !clk_rdy);

    // R8: dropping both requests stops the clock
    assert_drop_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rdy && !gts && !init_req && !acc_req) |=> !clk_rdy);

    // R10: error mode only while powered down
    assert_err_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERROR) |-> !clk_rdy);

endmodule

// File: rtl/wake_ctl_top.sv
module wake_ctl_top #(
    parameter int WAKE_CYC  = 4,
    parameter int SLEEP_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        fw_sleep_req,
    output logic        mac_clk_en,
    output logic        xtal_en
);
    logic       init_req, acc_req, xtal_req;
    logic       clk_rdy, gts;
    logic [2:0] mode;

    wake_regs #(.DATA_W(32)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .clk_rdy  (clk_rdy),
        .gts      (gts),
        .mode     (mode),
        .init_req (init_req),
        .acc_req  (acc_req),
        .xtal_req (xtal_req),
        .rd_data  (reg_rd_data)
    );

    wake_seq #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_req     (init_req),
        .acc_req      (acc_req),
        .xtal_req     (xtal_req),
        .fw_sleep_req (fw_sleep_req),
        .clk_rdy      (clk_rdy),
        .gts          (gts),
        .mode         (mode)
    );

    assign mac_clk_en = clk_rdy;
    assign xtal_en    = xtal_req;

endmodule

// File: tb/sim_wake_ctl_top.sv
module sim_wake_ctl_top;
    localparam int WK = 4;
    localparam int SL = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        fw_sleep;
    logic        mac_clk_en;
    logic        xtal_en;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    wake_ctl_top #(.WAKE_CYC(WK), .SLEEP_CYC(SL)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (wr_en),
        .reg_wr_data  (wr_data),
        .reg_rd_data  (rd_data),
        .fw_sleep_req (fw_sleep),
        .mac_clk_en   (mac_clk_en),
        .xtal_en      (xtal_en)
    );

    // write value, expected read word (sequencer stays off)
    localparam logic [63:0] VEC [5] = '{
        {32'hFFFF_FFF3, 32'h0100_0400},
        {32'h0000_0011, 32'h0200_0000},
        {32'h0700_0001, 32'h0200_0000},
        {32'h0000_0400, 32'h0100_0400},
        {32'h0000_0000, 32'h0200_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_rdy(output int k);
        k = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (rd_data[0]) break;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; fw_sleep = 1'b0;
        step(3);
        chk("R1 reset word", rd_data, 32'h0200_0000);
        chk("R1 clk/xtal", {30'd0, mac_clk_en, xtal_en}, 32'h0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", rd_data, 32'h0200_0000);

        for (int v = 0; v < 5; v++) begin
            wr(VEC[v][63:32]);
            chk("R2 R3 R9 table read", rd_data, VEC[v][31:0]);
            chk("R2 xtal_en", {31'd0, xtal_en}, {31'd0, VEC[v][10]});
        end

        // R4 wake by init-done
        wr(32'h0000_0004);
        wait_rdy(k);
        chk("R4 wake latency", k, WK + 1);
        chk("R4 ready word", rd_data, 32'h0000_0005);
        chk("R4 mac_clk_en", {31'd0, mac_clk_en}, 32'h1);
        wr(32'h0000_0011);
        chk("R3 ro write keeps ready", rd_data, 32'h0000_0001);
        wr(32'h0000_0004);

        // R5 access shields sleep
        wr(32'h0000_000C);
        fw_sleep = 1'b1;
        step(6);
        chk("R5 sleep ignored", rd_data, 32'h0000_000D);

        // R6 doze window
        wr(32'h0000_0004);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rd_data[4]) begin
                n++;
                chk("R6 ready held in doze", {31'd0, rd_data[0]}, 32'h1);
                chk("R9 doze mode", {29'd0, rd_data[26:24]}, 32'h0);
            end else if (n > 0) begin
                break;
            end
        end
        chk("R6 doze length", n, SL);
        chk("R6 off after doze", rd_data, 32'h0200_0004);
        chk("R6 mac_clk_en off", {31'd0, mac_clk_en}, 32'h0);

        // R7 held sleep keeps off; access wakes
        step(10);
        chk("R7 stays off", {31'd0, rd_data[0]}, 32'h0);
        wr(32'h0000_000C);
        wait_rdy(k);
        chk("R7 access wake latency", k, WK + 1);

        // R8 drop both requests from ON
        wr(32'h0000_0000);
        step(1);
        chk("R8 drop from on", rd_data, 32'h0200_0000);
        // R8 abort during wake
        wr(32'h0000_0008);
        step(1);
        wr(32'h0000_0000);
        step(WK + 3);
        chk("R8 wake aborted", rd_data, 32'h0200_0000);

        // R10 error mode
        fw_sleep = 1'b0;
        step(2);
        chk("R10 no error yet", rd_data, 32'h0200_0000);
        fw_sleep = 1'b1;
        step(1);
        chk("R10 error set", rd_data, 32'h0300_0000);
        wr(32'h0000_0400);
        chk("R10 error persists", rd_data, 32'h0300_0400);
        fw_sleep = 1'b0;
        wr(32'h0000_0408);
        step(1);
        chk("R10 error cleared by wake", rd_data, 32'h0000_0408);
        wait_rdy(k);
        chk("R9 ready mode", rd_data, 32'h0000_0409);
        wr(32'h0000_0400);
        step(1);
        chk("R9 mac down mode", rd_data, 32'h0100_0400);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule